// File: doc/BRIEF.md
# Multi-Source Reset Request Controller

This block gathers reset requests from many places and turns them into three reset classes. The sources are a power-on pin, a warm reset pin, three active-low request lines from the programmable fabric, a configuration-control load pulse, a security-manager request, two CPU watchdogs, two system watchdogs, a debug-port request and two software request bits. Each request is sorted into a cold, warm or debug class. A cold reset prevails over a warm one and also asserts every warm-domain and debug-domain output.

Every asynchronous request passes through a two-flop synchroniser clocked by the single reference clock. Each class then drives a hold counter, so its outputs stay asserted for a fixed number of cycles after the last request goes away. The block drives a cold-only fabric reset, a cold-or-warm fabric reset, a debug fabric reset and one reset line per module. A small write-one-to-set register holds the software request bits, and each bit clears itself once the reset it started is over. A cause code records which source started the most recent cold or warm reset.

Top module: `rst_req_ctrl`

## Requirements
- R1: A cold reset is requested by `por_n` low, `fab_cold_n` low, `cfg_load` high, `sec_req` high, or a write with `sw_wr`=1 and `sw_wdata[0]`=1.
- R2: A warm reset is requested by `warm_pin_n` low, `fab_warm_n` low, `cpu_wdt[0]` or `cpu_wdt[1]` high, `sys_wdt[0]` or `sys_wdt[1]` high, or a write with `sw_wr`=1 and `sw_wdata[1]`=1.
- R3: A debug reset is requested by `dbg_port_req` high or `fab_dbg_n` low. A debug request alone leaves `fab_cold_rst_n`, `fab_rst_n`, the warm-domain module lines and `cause` unchanged.
- R4: `fab_cold_rst_n` is low only during a cold reset. `fab_rst_n` is low during a cold or a warm reset. `fab_dbg_rst_n` is low during a debug or a cold reset. All three are active low.
- R5: A cold reset asserts all outputs, including every warm-domain and debug-domain output. When cold and warm requests start together, the recorded cause is the cold one.
- R6: A pin request held for one cycle asserts its class outputs by the third rising edge after it is driven. After the input is released, the outputs stay asserted and deassert on rising edge HOLD+2 (the 18th edge with HOLD=16).
- R7: Module line `mod_rst_n[i]` follows the debug class when bit i of DBG_MOD_MASK is 1, and the cold-or-warm class otherwise. The default mask 8'hC0 puts modules 6 and 7 in the debug domain.
- R8: While `por_n` is low, every reset output is low at once without a clock edge, `sw_ctrl` is 0 and `cause` is 1 (power-on). After release, all outputs deassert on rising edge HOLD+2.
- R9: A write sets, but never clears, the software bits (`sw_ctrl[0]` cold, `sw_ctrl[1]` warm). A software request asserts its class after the writing edge. The bit clears at the edge after that class's outputs deassert.
- R10: `cause` is captured only when a class starts from idle. The codes are: 1 power-on, 2 fabric cold, 3 configuration load, 4 security, 5 software cold, 8 warm pin, 9 fabric warm, 10 software warm, 11/12 CPU watchdog 0/1, 13/14 system watchdog 0/1. Among sources that start together, the lowest code wins, and a cold request during a warm reset records the cold code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on pin, active low, also the asynchronous reset of the block |
| warm_pin_n | input | 1 | Warm reset pin, active low |
| fab_cold_n | input | 1 | Fabric cold request, active low |
| fab_warm_n | input | 1 | Fabric warm request, active low |
| fab_dbg_n | input | 1 | Fabric debug request, active low |
| cfg_load | input | 1 | Configuration-control load pulse (cold) |
| sec_req | input | 1 | Security-manager reset request (cold) |
| cpu_wdt | input | 2 | CPU watchdog requests (warm) |
| sys_wdt | input | 2 | System watchdog requests (warm) |
| dbg_port_req | input | 1 | Debug-port reset request |
| sw_wr | input | 1 | Software control register write strobe |
| sw_wdata | input | 2 | Write-one-to-set data: bit0 cold, bit1 warm |
| sw_ctrl | output | 2 | Software request bits |
| cause | output | 4 | Code of the source of the most recent cold or warm reset |
| fab_cold_rst_n | output | 1 | Cold-only fabric reset, active low |
| fab_rst_n | output | 1 | Cold-or-warm fabric reset, active low |
| fab_dbg_rst_n | output | 1 | Debug fabric reset, active low |
| mod_rst_n | output | NUM_MOD | Per-module resets, active low |

## Verification
The assertions assume that `por_n` is the only input that acts without a clock and that the software strobe is synchronous to `clk`. The other request lines may change at any time, because they pass through the synchroniser. The stimulus changes every input on the falling edge, releases the power-on pin before any other request, and holds each pin request for at least one full cycle so that the synchroniser cannot miss it. A new request is driven only after the previous reset has fully ended. The one exception is the deliberate case of a cold request arriving during a warm reset.

// File: rtl/rst_req_pkg.sv
package rst_req_pkg;

  typedef enum logic [3:0] {
    CAUSE_NONE     = 4'd0,
    CAUSE_POR      = 4'd1,
    CAUSE_FAB_COLD = 4'd2,
    CAUSE_CFG_LOAD = 4'd3,
    CAUSE_SECURE   = 4'd4,
    CAUSE_SW_COLD  = 4'd5,
    CAUSE_WARM_PIN = 4'd8,
    CAUSE_FAB_WARM = 4'd9,
    CAUSE_SW_WARM  = 4'd10,
    CAUSE_CPU_WDT0 = 4'd11,
    CAUSE_CPU_WDT1 = 4'd12,
    CAUSE_SYS_WDT0 = 4'd13,
    CAUSE_SYS_WDT1 = 4'd14
  } rst_cause_e;

  // Positions of the synchronised request vector (all active high)
  localparam int SRC_POR      = 0;
  localparam int SRC_FAB_COLD = 1;
  localparam int SRC_CFG      = 2;
  localparam int SRC_SEC      = 3;
  localparam int SRC_WPIN     = 4;
  localparam int SRC_FAB_WARM = 5;
  localparam int SRC_CPU0     = 6;
  localparam int SRC_CPU1     = 7;
  localparam int SRC_SYS0     = 8;
  localparam int SRC_SYS1     = 9;
  localparam int SRC_DBG_PORT = 10;
  localparam int SRC_FAB_DBG  = 11;
  localparam int NUM_SRC      = 12;

  // Class indices
  localparam int CLS_COLD = 0;
  localparam int CLS_WARM = 1;
  localparam int CLS_DBG  = 2;
  localparam int NUM_CLS  = 3;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  function automatic logic any_cold(src_vec_t s, logic sw);
    return s[SRC_POR] | s[SRC_FAB_COLD] | s[SRC_CFG] | s[SRC_SEC] | sw;
  endfunction

  function automatic logic any_warm(src_vec_t s, logic sw);
    return s[SRC_WPIN] | s[SRC_FAB_WARM] | s[SRC_CPU0] | s[SRC_CPU1] |
           s[SRC_SYS0] | s[SRC_SYS1] | sw;
  endfunction

  function automatic logic any_dbg(src_vec_t s);
    return s[SRC_DBG_PORT] | s[SRC_FAB_DBG];
  endfunction

  function automatic rst_cause_e cold_code(src_vec_t s, logic sw);
    if (s[SRC_POR])           return CAUSE_POR;
    else if (s[SRC_FAB_COLD]) return CAUSE_FAB_COLD;
    else if (s[SRC_CFG])      return CAUSE_CFG_LOAD;
    else if (s[SRC_SEC])      return CAUSE_SECURE;
    else if (sw)              return CAUSE_SW_COLD;
    return CAUSE_NONE;
  endfunction

  function automatic rst_cause_e warm_code(src_vec_t s, logic sw);
    if (s[SRC_WPIN])          return CAUSE_WARM_PIN;
    else if (s[SRC_FAB_WARM]) return CAUSE_FAB_WARM;
    else if (sw)              return CAUSE_SW_WARM;
    else if (s[SRC_CPU0])     return CAUSE_CPU_WDT0;
    else if (s[SRC_CPU1])     return CAUSE_CPU_WDT1;
    else if (s[SRC_SYS0])     return CAUSE_SYS_WDT0;
    else if (s[SRC_SYS1])     return CAUSE_SYS_WDT1;
    return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/rst_sync_bank.sv
module rst_sync_bank #(
  parameter int WIDTH  = 12,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  // Reset value is "requesting" so a power-on keeps every class busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rst_class_hold.sv
module rst_class_hold #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic active_o
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= LOAD;
    else if (req_i)          cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> active_o);  // R6
  AST_HOLD_NO_EARLY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_o) |-> !$past(req_i));  // R6
endmodule

// File: rtl/rst_req_ctrl.sv
module rst_req_ctrl
  import rst_req_pkg::*;
#(
  parameter int                 NUM_MOD      = 8,
  parameter logic [NUM_MOD-1:0] DBG_MOD_MASK = 8'hC0,
  parameter int                 HOLD         = 16,
  parameter int                 SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               warm_pin_n,
  input  logic               fab_cold_n,
  input  logic               fab_warm_n,
  input  logic               fab_dbg_n,
  input  logic               cfg_load,
  input  logic               sec_req,
  input  logic [1:0]         cpu_wdt,
  input  logic [1:0]         sys_wdt,
  input  logic               dbg_port_req,
  input  logic               sw_wr,
  input  logic [1:0]         sw_wdata,
  output logic [1:0]         sw_ctrl,
  output logic [3:0]         cause,
  output logic               fab_cold_rst_n,
  output logic               fab_rst_n,
  output logic               fab_dbg_rst_n,
  output logic [NUM_MOD-1:0] mod_rst_n
);
  src_vec_t raw_req, sync_req;

  always_comb begin
    raw_req               = '0;
    raw_req[SRC_POR]      = ~por_n;
    raw_req[SRC_FAB_COLD] = ~fab_cold_n;
    raw_req[SRC_CFG]      = cfg_load;
    raw_req[SRC_SEC]      = sec_req;
    raw_req[SRC_WPIN]     = ~warm_pin_n;
    raw_req[SRC_FAB_WARM] = ~fab_warm_n;
    raw_req[SRC_CPU0]     = cpu_wdt[0];
    raw_req[SRC_CPU1]     = cpu_wdt[1];
    raw_req[SRC_SYS0]     = sys_wdt[0];
    raw_req[SRC_SYS1]     = sys_wdt[1];
    raw_req[SRC_DBG_PORT] = dbg_port_req;
    raw_req[SRC_FAB_DBG]  = ~fab_dbg_n;
  end

  rst_sync_bank #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(por_n), .async_i(raw_req), .sync_o(sync_req)
  );

  // Named internal events
  logic sw_cold_set, sw_warm_set;
  logic cold_req, warm_own_req, dbg_own_req;
  logic [NUM_CLS-1:0] cls_req, cls_act, cls_act_q;
  logic cold_start, warm_start, cold_done, warm_done;

  assign sw_cold_set  = sw_wr & sw_wdata[0];
  assign sw_warm_set  = sw_wr & sw_wdata[1];
  assign cold_req     = any_cold(sync_req, sw_cold_set);
  assign warm_own_req = any_warm(sync_req, sw_warm_set);
  assign dbg_own_req  = any_dbg(sync_req);

  assign cls_req[CLS_COLD] = cold_req;
  assign cls_req[CLS_WARM] = warm_own_req | cold_req;
  assign cls_req[CLS_DBG]  = dbg_own_req | cold_req;

  for (genvar gc = 0; gc < NUM_CLS; gc++) begin : g_cls
    rst_class_hold #(.HOLD(HOLD)) u_hold (
      .clk(clk), .rst_n(por_n), .req_i(cls_req[gc]), .active_o(cls_act[gc])
    );
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cls_act_q <= '1;
    else        cls_act_q <= cls_act;
  end

  assign cold_start = cold_req & ~cls_act[CLS_COLD];
  assign warm_start = warm_own_req & ~cls_act[CLS_WARM];
  assign cold_done  = cls_act_q[CLS_COLD] & ~cls_act[CLS_COLD];
  assign warm_done  = cls_act_q[CLS_WARM] & ~cls_act[CLS_WARM];

  // Cause record: cold code wins over warm code
  rst_cause_e cause_q;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          cause_q <= CAUSE_POR;
    else if (cold_start) cause_q <= cold_code(sync_req, sw_cold_set);
    else if (warm_start) cause_q <= warm_code(sync_req, sw_warm_set);
  end
  assign cause = cause_q;

  // Software request bits: write-one-to-set, cleared when their class ends
  logic [1:0] sw_ctrl_q;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sw_ctrl_q <= '0;
    else        sw_ctrl_q <= (sw_ctrl_q & ~{warm_done, cold_done}) |
                             {sw_warm_set, sw_cold_set};
  end
  assign sw_ctrl = sw_ctrl_q;

  assign fab_cold_rst_n = ~cls_act[CLS_COLD];
  assign fab_rst_n      = ~cls_act[CLS_WARM];
  assign fab_dbg_rst_n  = ~cls_act[CLS_DBG];

  for (genvar gm = 0; gm < NUM_MOD; gm++) begin : g_mod
    if (DBG_MOD_MASK[gm]) begin : g_dbg
      assign mod_rst_n[gm] = ~cls_act[CLS_DBG];
    end else begin : g_warm
      assign mod_rst_n[gm] = ~cls_act[CLS_WARM];
    end
    AST_MOD_COLD: assert property (@(posedge clk) disable iff (!por_n)
      !fab_cold_rst_n |-> !mod_rst_n[gm]);  // R7
  end

  AST_COLD_COVERS_ALL: assert property (@(posedge clk) disable iff (!por_n)
    !fab_cold_rst_n |-> (!fab_rst_n && !fab_dbg_rst_n));  // R5
  AST_CAUSE_COLD_WINS: assert property (@(posedge clk) disable iff (!por_n)
    cold_start |=> (cause < 4'd8));  // R10
  AST_SW_COLD_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    (cold_done && !sw_cold_set) |=> !sw_ctrl[0]);  // R9
  AST_SW_WARM_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    (warm_done && !sw_warm_set) |=> !sw_ctrl[1]);  // R9
endmodule

// File: tb/rst_req_ctrl_test.sv
`timescale 1ns/1ps
module rst_req_ctrl_test;
  localparam logic [7:0] MASK = 8'hC0;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic por_n, warm_pin_n, fab_cold_n, fab_warm_n, fab_dbg_n;
  logic cfg_load, sec_req, dbg_port_req, sw_wr;
  logic [1:0] cpu_wdt, sys_wdt, sw_wdata, sw_ctrl;
  logic [3:0] cause;
  logic fab_cold_rst_n, fab_rst_n, fab_dbg_rst_n;
  logic [7:0] mod_rst_n;

  rst_req_ctrl uut (
    .clk(clk), .por_n(por_n), .warm_pin_n(warm_pin_n), .fab_cold_n(fab_cold_n),
    .fab_warm_n(fab_warm_n), .fab_dbg_n(fab_dbg_n), .cfg_load(cfg_load),
    .sec_req(sec_req), .cpu_wdt(cpu_wdt), .sys_wdt(sys_wdt),
    .dbg_port_req(dbg_port_req), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .sw_ctrl(sw_ctrl), .cause(cause), .fab_cold_rst_n(fab_cold_rst_n),
    .fab_rst_n(fab_rst_n), .fab_dbg_rst_n(fab_dbg_rst_n), .mod_rst_n(mod_rst_n)
  );

  typedef struct {string tag; logic [16:0] exp;} item_t;
  item_t sb_q[$];
  event mon_ev;
  int checks = 0, errors = 0;

  // Expected output word {cold_n, rst_n, dbg_n, mods, sw, cause}
  function automatic logic [16:0] mk(bit c, bit w, bit d, logic [1:0] sw, logic [3:0] cs);
    bit wa, da;
    logic [7:0] m;
    wa = c | w;
    da = c | d;
    for (int i = 0; i < 8; i++) m[i] = MASK[i] ? !da : !wa;
    return {!c, !wa, !da, m, sw, cs};
  endfunction

  // Monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(mon_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [16:0] act;
        it  = sb_q.pop_front();
        act = {fab_cold_rst_n, fab_rst_n, fab_dbg_rst_n, mod_rst_n, sw_ctrl, cause};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_out(string tag, logic [16:0] e);
    item_t it;
    it.tag = tag;
    it.exp = e;
    sb_q.push_back(it);
    -> mon_ev;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_inputs();
    warm_pin_n = 1; fab_cold_n = 1; fab_warm_n = 1; fab_dbg_n = 1;
    cfg_load = 0; sec_req = 0; dbg_port_req = 0; sw_wr = 0;
    cpu_wdt = 0; sys_wdt = 0; sw_wdata = 0;
  endtask

  // Caller drives a pin request at a falling edge; held one cycle here
  task automatic pin_pulse(string tag, bit c, bit w, bit d, logic [3:0] cs);
    wait_n(1);
    idle_inputs();
    wait_n(2);
    expect_out({tag, " asserted (R6)"}, mk(c, w, d, 2'b00, cs));
    wait_n(15);
    expect_out({tag, " still held (R6)"}, mk(c, w, d, 2'b00, cs));
    wait_n(1);
    expect_out({tag, " released (R6)"}, mk(0, 0, 0, 2'b00, cs));
    wait_n(2);
  endtask

  task automatic sw_pulse(string tag, bit c, logic [1:0] bits, logic [3:0] cs);
    sw_wr = 1; sw_wdata = bits;
    wait_n(1);
    idle_inputs();
    expect_out({tag, " set (R9)"}, mk(c, !c, 0, bits, cs));
    wait_n(15);
    expect_out({tag, " held (R9)"}, mk(c, !c, 0, bits, cs));
    wait_n(1);
    expect_out({tag, " ended, bit kept (R9)"}, mk(0, 0, 0, bits, cs));
    wait_n(1);
    expect_out({tag, " bit self-cleared (R9)"}, mk(0, 0, 0, 2'b00, cs));
    wait_n(2);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    por_n = 0;
    idle_inputs();
    wait_n(2);
    expect_out("R8 reset state", mk(1, 0, 0, 2'b00, 4'd1));
    por_n = 1;
    wait_n(17);
    expect_out("R8 held after power-on", mk(1, 0, 0, 2'b00, 4'd1));
    wait_n(1);
    expect_out("R8 released after power-on", mk(0, 0, 0, 2'b00, 4'd1));
    wait_n(2);

    // R2 / R4 / R7 warm via fabric line
    fab_warm_n = 0;
    pin_pulse("R2 fabric warm", 0, 1, 0, 4'd9);
    sys_wdt = 2'b10;
    pin_pulse("R2 system watchdog 1", 0, 1, 0, 4'd14);
    cpu_wdt = 2'b01; fab_warm_n = 0;
    pin_pulse("R10 warm priority fabric over cpu wdt", 0, 1, 0, 4'd9);
    cpu_wdt = 2'b10;
    pin_pulse("R2 cpu watchdog 1", 0, 1, 0, 4'd12);
    warm_pin_n = 0;
    pin_pulse("R2 warm pin", 0, 1, 0, 4'd8);

    // R3 debug only, cause unchanged
    dbg_port_req = 1;
    pin_pulse("R3 debug port", 0, 0, 1, 4'd8);
    fab_dbg_n = 0;
    pin_pulse("R3 fabric debug", 0, 0, 1, 4'd8);

    // R1 / R5 cold
    cfg_load = 1;
    pin_pulse("R1 config load", 1, 0, 0, 4'd3);
    fab_cold_n = 0;
    pin_pulse("R1 fabric cold", 1, 0, 0, 4'd2);
    sec_req = 1; warm_pin_n = 0;
    pin_pulse("R5 cold beats warm", 1, 0, 0, 4'd4);

    // R10 escalation: cold arrives during warm
    fab_warm_n = 0;
    wait_n(1);
    idle_inputs();
    wait_n(2);
    expect_out("R10 warm before escalation", mk(0, 1, 0, 2'b00, 4'd9));
    cfg_load = 1;
    wait_n(1);
    idle_inputs();
    wait_n(2);
    expect_out("R10 escalated to cold", mk(1, 0, 0, 2'b00, 4'd3));
    wait_n(15);
    expect_out("R10 escalated held (R6)", mk(1, 0, 0, 2'b00, 4'd3));
    wait_n(1);
    expect_out("R10 escalated released (R6)", mk(0, 0, 0, 2'b00, 4'd3));
    wait_n(2);

    // R9 software bits
    sw_pulse("R9 software cold", 1, 2'b01, 4'd5);
    sw_pulse("R9 software warm", 0, 2'b10, 4'd10);

    // R8 asynchronous power-on assertion mid-cycle
    #1 por_n = 0;
    #0.5;
    checks++;
    if ({fab_cold_rst_n, fab_rst_n, fab_dbg_rst_n, mod_rst_n} !== 11'd0) begin
      errors++;
      $display("FAIL R8 async assert: got %h expected 000",
               {fab_cold_rst_n, fab_rst_n, fab_dbg_rst_n, mod_rst_n});
    end
    wait_n(1);
    expect_out("R8 cause after second power-on", mk(1, 0, 0, 2'b00, 4'd1));
    wait_n(1);
    finish_run();
  end
endmodule